// File: doc/BRIEF.md
# SMBus block transfer buffer

This block sits between a byte-wide register port and an SMBus/I2C bus engine and carries the data of block transactions in both directions. Software programs a target address, a command byte, a byte count and a protocol code, then sets a start bit. The bus engine pulls write bytes from the block, or pushes read bytes into it, through a simple valid/ready byte stream.

Two data paths exist. With the buffer enable set, a parameterised store (32 bytes by default) is filled or drained through the block-data register, and every access moves an auto-incrementing index. Reading the control register returns that index to zero. With the buffer disabled, or for an I2C-style block read, a single byte register is exchanged one byte at a time. After each byte a byte-done flag rises, and the bus engine is held off until software writes the flag back to clear it. In this path a "last byte" protocol code tells the engine to NACK the final read byte.

The block checks the byte count. For writes and I2C-style reads, software supplies the count in data0. For SMBus block reads, the first byte from the slave is the count, and the block stores it in data0. A count outside 1..32 raises a count-error flag and stops the stream.

Top module: `smb_blkbuf`

Register map. The address is 3 bits:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 6 is start and reads back 0; bit 5 is the last-byte flag; bits 4:2 are the protocol type |
| 1 | status | bit 7 is byte-done; bit 3 is count error; both are cleared by writing 1 |
| 2 | data0 | byte count |
| 3 | data1 | command byte for an I2C-style read |
| 4 | block data | buffer or byte register |
| 5 | aux | bit 0 enables the buffer |
| 6 | command | command byte |
| 7 | target address | bit 0 is the read/write bit, 1 for read |

Protocol codes:

| Code | Transaction |
|---|---|
| 0x14 | SMBus block |
| 0x18 | I2C-style block read |
| 0x34 | SMBus block, last byte |
| 0x38 | I2C-style block read, last byte |

## Requirements
- R1: After reset every register reads 0x00, and both eng_tx_valid and eng_rx_ready are low.
- R2: In buffered mode (aux bit 0 set and the type is not I2C-style), each block-data write stores at the software index and advances it. Each block-data read returns the byte at the index and advances it. A read of the control register (address 0) sets the index to 0.
- R3: Block-data accesses past entry DEPTH-1 in buffered mode are ignored: writes change no entry, and reads return 0x00.
- R4: In a buffered block write (address bit 0 = 0), after start the engine stream presents exactly data0 bytes, in buffer order, one per handshake (eng_tx_req and eng_tx_valid). eng_tx_valid then stays low.
- R5: A start with data0 of 0 or above 32 on a write or an I2C-style read sets status bit 3 and keeps both stream directions idle. Writing 1 to status bit 3 clears the flag.
- R6: In an SMBus block read (address bit 0 = 1, type 0x14) the first engine byte goes into data0 as the count. The next count bytes fill the buffer, and after them eng_rx_ready is low.
- R7: A count byte from the slave below 1 or above 32 sets status bit 3 and drops eng_rx_ready.
- R8: In byte-by-byte mode each transferred byte sets status bit 7, and the stream stalls (eng_tx_valid or eng_rx_ready low) until software writes 1 to bit 7.
- R9: eng_last is high for the final byte. In buffered mode this is derived from the count. In byte-by-byte mode it follows control bit 5, which is set by codes 0x34 and 0x38.
- R10: With type 0x18, eng_addr_byte has bit 0 cleared, eng_cmd_byte is data1, eng_read is high, and no count byte is taken. The transfer uses the byte register even when the buffer is enabled.
- R11: For SMBus types, eng_addr_byte equals the target-address register, eng_cmd_byte equals the command register, and eng_read equals address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; the read side effects take place at the clock edge |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| eng_addr_byte | output | DW | Address byte for the engine to send |
| eng_cmd_byte | output | DW | Command byte for the engine to send |
| eng_read | output | 1 | The transaction is a read |
| eng_last | output | 1 | The current byte is the final one; the engine NACKs it on a read |
| eng_tx_req | input | 1 | Engine requests the next write byte |
| eng_tx_valid | output | 1 | A write byte is available |
| eng_tx_data | output | DW | Write byte |
| eng_rx_valid | input | 1 | Engine offers a read byte |
| eng_rx_ready | output | 1 | Block accepts a read byte; low means the engine stretches |
| eng_rx_data | input | DW | Read byte |

## Verification
The assertions check on every cycle the invariants of the stream:
- a pending byte-done in byte-by-byte mode stalls both directions;
- a count error silences the stream;
- the engine index never runs past data0;
- the software index never passes DEPTH;
- an I2C-style read never drives the read/write bit.

The bench scenarios show the ordering and content properties, which no single cycle can reveal: buffered fills and drains at every count from 1 to 32; index reset on a control read; ignored overflow accesses; count capture from the slave; and the last-byte marker landing on exactly the final byte.

// File: rtl/smb_blkbuf_pkg.sv
// Package: register addresses, bit positions and protocol type values
// shared by the block-transfer buffer, its checker and its bench.
package smb_blkbuf_pkg;
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_DATA0 = 3'd2;
    localparam logic [2:0] RA_DATA1 = 3'd3;
    localparam logic [2:0] RA_BLK   = 3'd4;
    localparam logic [2:0] RA_AUX   = 3'd5;
    localparam logic [2:0] RA_CMD   = 3'd6;
    localparam logic [2:0] RA_ADDR  = 3'd7;

    localparam int CTRL_START_BIT = 6;
    localparam int CTRL_LAST_BIT  = 5;
    localparam int STAT_BD_BIT    = 7;
    localparam int STAT_CERR_BIT  = 3;

    // Protocol type field, control bits 4:2
    localparam logic [2:0] TYPE_SMB_BLOCK = 3'b101;
    localparam logic [2:0] TYPE_I2C_READ  = 3'b110;
endpackage

// File: rtl/blkbuf_index.sv
// Saturating index counter.
// Assumes: clr has priority over inc; the count holds at LIMIT.
module blkbuf_index #(
    parameter int IW    = 6,
    parameter int LIMIT = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [IW-1:0] val
);
    // Purpose: clear, or advance up to LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n)                          val <= '0;
        else if (clr)                        val <= '0;
        else if (inc && val < IW'(LIMIT))    val <= val + 1'b1;
    end
endmodule

// File: rtl/blkbuf_store.sv
// Byte store with two write ports and two combinational read ports.
// Assumes: port b wins when both ports write the same entry; any index at or
// above DEPTH writes nothing and reads zero.
module blkbuf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [IW-1:0] a_idx,
    input  logic [DW-1:0] a_wd,
    output logic [DW-1:0] a_rd,
    input  logic          b_we,
    input  logic [IW-1:0] b_idx,
    input  logic [DW-1:0] b_wd,
    output logic [DW-1:0] b_rd
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] ent [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [DW-1:0] cell_q;
        // Purpose: hold one entry, updated by whichever port addresses it
        always_ff @(posedge clk) begin
            if (!rst_n)                               cell_q <= '0;
            else if (b_we && b_idx == IW'(e))         cell_q <= b_wd;
            else if (a_we && a_idx == IW'(e))         cell_q <= a_wd;
        end
        assign ent[e] = cell_q;
    end

    assign a_rd = (a_idx < IW'(DEPTH)) ? ent[a_idx[AW-1:0]] : '0;
    assign b_rd = (b_idx < IW'(DEPTH)) ? ent[b_idx[AW-1:0]] : '0;
endmodule

// File: rtl/smb_blkbuf.sv
// SMBus block-transfer buffer: register port on one side, byte stream to the
// bus engine on the other. Buffered mode uses an indexed store; byte-by-byte
// mode uses one byte register with a byte-done handshake.
// Assumes: one transaction is in flight at a time, and software does not
// rewrite data0 while the engine stream is active.
module smb_blkbuf
    import smb_blkbuf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] eng_addr_byte,
    output logic [DW-1:0] eng_cmd_byte,
    output logic          eng_read,
    output logic          eng_last,
    input  logic          eng_tx_req,
    output logic          eng_tx_valid,
    output logic [DW-1:0] eng_tx_data,
    input  logic          eng_rx_valid,
    output logic          eng_rx_ready,
    input  logic [DW-1:0] eng_rx_data
);
    localparam int IW = $clog2(DEPTH + 1);

    logic [DW-1:0] ctrl_q, data0_q, data1_q, cmd_q, addr_q, blk_q;
    logic          aux_en_q, byte_done_q, cnt_err_q, active_q, cnt_known_q;
    logic [IW-1:0] sw_idx, eng_idx;
    logic [DW-1:0] sw_rd_byte, eng_rd_byte;

    // Register decode
    logic wr_ctrl, rd_ctrl, wr_stat, blk_acc, start;
    assign wr_ctrl = reg_wr && reg_addr == RA_CTRL;
    assign rd_ctrl = reg_rd && reg_addr == RA_CTRL;
    assign wr_stat = reg_wr && reg_addr == RA_STAT;
    assign blk_acc = (reg_wr || reg_rd) && reg_addr == RA_BLK;
    assign start   = wr_ctrl && reg_wdata[CTRL_START_BIT];

    // Mode decode from the stored control value
    logic i2c_mode, buf_mode, dir_rd;
    assign i2c_mode = ctrl_q[4:2] == TYPE_I2C_READ;
    assign buf_mode = aux_en_q && !i2c_mode;
    assign dir_rd   = i2c_mode || addr_q[0];

    // Decode of a control write that carries start
    logic new_i2c, new_known;
    assign new_i2c   = reg_wdata[4:2] == TYPE_I2C_READ;
    assign new_known = !(!new_i2c && addr_q[0]);

    function automatic logic cnt_ok(input logic [DW-1:0] c);
        return (c != '0) && (c <= DW'(DEPTH));
    endfunction

    // Engine stream
    logic [DW-1:0] eng_idx_ext;
    logic          eng_more, tx_fire, rx_fire, rx_cnt, rx_dat;
    assign eng_idx_ext  = {{(DW-IW){1'b0}}, eng_idx};
    assign eng_more     = eng_idx_ext < data0_q;
    assign eng_tx_valid = active_q && !dir_rd && !cnt_err_q && eng_more
                          && (buf_mode || !byte_done_q);
    assign eng_rx_ready = active_q && dir_rd && !cnt_err_q
                          && (!cnt_known_q || eng_more)
                          && (buf_mode || !byte_done_q);
    assign tx_fire      = eng_tx_req && eng_tx_valid;
    assign rx_fire      = eng_rx_valid && eng_rx_ready;
    assign rx_cnt       = rx_fire && !cnt_known_q;
    assign rx_dat       = rx_fire && cnt_known_q;
    assign eng_tx_data  = buf_mode ? eng_rd_byte : blk_q;
    assign eng_last     = buf_mode ? (cnt_known_q && (eng_idx_ext + DW'(1)) == data0_q)
                                   : ctrl_q[CTRL_LAST_BIT];
    assign eng_read      = dir_rd;
    assign eng_addr_byte = i2c_mode ? {addr_q[DW-1:1], 1'b0} : addr_q;
    assign eng_cmd_byte  = i2c_mode ? data1_q : cmd_q;

    blkbuf_index #(.IW(IW), .LIMIT(DEPTH)) u_sw_idx (
        .clk(clk), .rst_n(rst_n), .clr(rd_ctrl),
        .inc(buf_mode && blk_acc), .val(sw_idx));

    blkbuf_index #(.IW(IW), .LIMIT(DEPTH)) u_eng_idx (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .inc(tx_fire || rx_dat), .val(eng_idx));

    blkbuf_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we(buf_mode && reg_wr && reg_addr == RA_BLK), .a_idx(sw_idx),
        .a_wd(reg_wdata), .a_rd(sw_rd_byte),
        .b_we(buf_mode && rx_dat), .b_idx(eng_idx),
        .b_wd(eng_rx_data), .b_rd(eng_rd_byte));

    // Purpose: software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            data1_q  <= '0;
            cmd_q    <= '0;
            addr_q   <= '0;
            aux_en_q <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_CTRL:  ctrl_q   <= reg_wdata & ~(DW'(1) << CTRL_START_BIT);
                RA_DATA1: data1_q  <= reg_wdata;
                RA_CMD:   cmd_q    <= reg_wdata;
                RA_ADDR:  addr_q   <= reg_wdata;
                RA_AUX:   aux_en_q <= reg_wdata[0];
                default:  ;
            endcase
        end
    end

    // Purpose: byte count, written by software or captured from the slave
    always_ff @(posedge clk) begin
        if (!rst_n)                               data0_q <= '0;
        else if (rx_cnt)                          data0_q <= eng_rx_data;
        else if (reg_wr && reg_addr == RA_DATA0)  data0_q <= reg_wdata;
    end

    // Purpose: byte register used by the byte-by-byte path
    always_ff @(posedge clk) begin
        if (!rst_n)                                          blk_q <= '0;
        else if (!buf_mode && rx_dat)                        blk_q <= eng_rx_data;
        else if (!buf_mode && reg_wr && reg_addr == RA_BLK)  blk_q <= reg_wdata;
    end

    // Purpose: transaction state, count qualification and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= 1'b0;
            cnt_known_q <= 1'b0;
            cnt_err_q   <= 1'b0;
            byte_done_q <= 1'b0;
        end else if (start) begin
            active_q    <= 1'b1;
            cnt_known_q <= new_known;
            cnt_err_q   <= new_known && !cnt_ok(data0_q);
            byte_done_q <= 1'b0;
        end else begin
            if (rx_cnt) begin
                cnt_known_q <= 1'b1;
                cnt_err_q   <= !cnt_ok(eng_rx_data);
            end else if (wr_stat && reg_wdata[STAT_CERR_BIT]) begin
                cnt_err_q   <= 1'b0;
            end
            if (!buf_mode && (tx_fire || rx_dat))
                byte_done_q <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_BD_BIT])
                byte_done_q <= 1'b0;
        end
    end

    // Purpose: register read mux
    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = ctrl_q;
            RA_STAT:  reg_rdata = (DW'(byte_done_q) << STAT_BD_BIT)
                                | (DW'(cnt_err_q) << STAT_CERR_BIT);
            RA_DATA0: reg_rdata = data0_q;
            RA_DATA1: reg_rdata = data1_q;
            RA_BLK:   reg_rdata = buf_mode ? sw_rd_byte : blk_q;
            RA_AUX:   reg_rdata = DW'(aux_en_q);
            RA_CMD:   reg_rdata = cmd_q;
            default:  reg_rdata = addr_q;
        endcase
    end
endmodule

// File: rtl/smb_blkbuf_chk.sv
// Checker for smb_blkbuf: stream invariants, attached by bind.
// Assumes: it is connected to the internal state of the top through the bind.
module smb_blkbuf_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int IW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          buf_mode,
    input logic          i2c_mode,
    input logic          byte_done_q,
    input logic          cnt_err_q,
    input logic          eng_tx_req,
    input logic          eng_tx_valid,
    input logic          eng_rx_valid,
    input logic          eng_rx_ready,
    input logic          cnt_known_q,
    input logic [DW-1:0] eng_addr_byte,
    input logic [IW-1:0] eng_idx,
    input logic [IW-1:0] sw_idx,
    input logic [DW-1:0] data0_q
);
    // R8
    bd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && byte_done_q) |-> (!eng_tx_valid && !eng_rx_ready));

    // R8
    bd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && !start && ((eng_tx_req && eng_tx_valid)
            || (eng_rx_valid && eng_rx_ready && cnt_known_q))) |=> byte_done_q);

    // R5
    cnt_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err_q |-> (!eng_tx_valid && !eng_rx_ready));

    // R4
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid |-> ({{(DW-IW){1'b0}}, eng_idx} < data0_q));

    // R3
    sw_idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_idx <= IW'(DEPTH));

    // R10
    i2c_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_mode |-> !eng_addr_byte[0]);
endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_mode(buf_mode),
    .i2c_mode(i2c_mode), .byte_done_q(byte_done_q), .cnt_err_q(cnt_err_q),
    .eng_tx_req(eng_tx_req), .eng_tx_valid(eng_tx_valid),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
    .cnt_known_q(cnt_known_q), .eng_addr_byte(eng_addr_byte),
    .eng_idx(eng_idx), .sw_idx(sw_idx), .data0_q(data0_q));

// File: tb/smb_blkbuf_tb.sv
// Bench for smb_blkbuf: count sweeps over both paths, with expected bytes
// computed from a formula.
module smb_blkbuf_tb;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, eng_addr_byte, eng_cmd_byte, eng_tx_data;
    logic       eng_read, eng_last, eng_tx_valid, eng_rx_ready;
    logic       eng_tx_req = 1'b0, eng_rx_valid = 1'b0;
    logic [7:0] eng_rx_data = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    smb_blkbuf #(.DW(8), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_addr_byte(eng_addr_byte), .eng_cmd_byte(eng_cmd_byte),
        .eng_read(eng_read), .eng_last(eng_last),
        .eng_tx_req(eng_tx_req), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_rx_valid(eng_rx_valid),
        .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data));

    function automatic logic [7:0] pat(input int n, input int k);
        return 8'((n * 29 + k * 11 + 3) & 255);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic pull(output logic v, output logic [7:0] d, output logic l);
        @(negedge clk);
        eng_tx_req = 1'b1;
        #1 v = eng_tx_valid; d = eng_tx_data; l = eng_last;
        @(posedge clk); #1 eng_tx_req = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, output logic acc, output logic l);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        #1 acc = eng_rx_ready; l = eng_last;
        @(posedge clk); #1 eng_rx_valid = 1'b0;
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic v, l, acc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 0);
        end
        #1 chk("R1 tx_valid", eng_tx_valid, 0);
        chk("R1 rx_ready", eng_rx_ready, 0);

        // R4 R2 R9 R11: buffered write sweep
        wr(3'd5, 8'h01);
        wr(3'd7, 8'h50);
        wr(3'd6, 8'h3C);
        for (int n = 1; n <= DEPTH; n++) begin
            wr(3'd0, 8'h14);
            rd(3'd0, d);
            wr(3'd2, 8'(n));
            for (int k = 0; k < n; k++) wr(3'd4, pat(n, k));
            wr(3'd0, 8'h54);
            if (n == 1) begin
                chk("R11 addr", eng_addr_byte, 8'h50);
                chk("R11 cmd", eng_cmd_byte, 8'h3C);
                chk("R11 read", eng_read, 0);
            end
            for (int k = 0; k < n; k++) begin
                pull(v, d, l);
                chk("R4 valid", v, 1);
                chk("R4 data", d, pat(n, k));
                chk("R9 last buffered", l, (k == n - 1));
            end
            pull(v, d, l);
            chk("R4 end", v, 0);
            rd(3'd0, d);
            for (int k = 0; k < n; k++) begin
                rd(3'd4, d);
                chk("R2 readback", d, pat(n, k));
            end
        end

        // R3: overflow past the last entry
        rd(3'd0, d);
        for (int k = 0; k < DEPTH; k++) wr(3'd4, pat(7, k));
        wr(3'd4, 8'hAA);
        rd(3'd0, d);
        for (int k = 0; k < DEPTH; k++) begin
            rd(3'd4, d);
            chk("R3 intact", d, pat(7, k));
        end
        rd(3'd4, d);
        chk("R3 over read", d, 0);

        // R5: bad write counts
        wr(3'd2, 8'd0);
        wr(3'd0, 8'h54);
        rd(3'd1, d);
        chk("R5 count 0 flag", d, 8'h08);
        #1 chk("R5 count 0 idle", eng_tx_valid, 0);
        wr(3'd1, 8'h08);
        rd(3'd1, d);
        chk("R5 clear", d, 0);
        wr(3'd2, 8'd33);
        wr(3'd0, 8'h54);
        rd(3'd1, d);
        chk("R5 count 33 flag", d, 8'h08);
        wr(3'd1, 8'h08);

        // R6: buffered SMBus block read sweep
        wr(3'd7, 8'hA1);
        for (int n = 1; n <= DEPTH; n++) begin
            wr(3'd0, 8'h54);
            push(8'(n), acc, l);
            chk("R6 count accepted", acc, 1);
            for (int k = 0; k < n; k++) begin
                push(pat(n + 40, k), acc, l);
                chk("R6 accept", acc, 1);
                chk("R9 last read", l, (k == n - 1));
            end
            push(8'h5A, acc, l);
            chk("R6 end", acc, 0);
            rd(3'd2, d);
            chk("R6 data0", d, n);
            rd(3'd0, d);
            for (int k = 0; k < n; k++) begin
                rd(3'd4, d);
                chk("R6 readback", d, pat(n + 40, k));
            end
        end

        // R7: slave count out of range
        wr(3'd0, 8'h54);
        push(8'd0, acc, l);
        rd(3'd1, d);
        chk("R7 count 0 flag", d, 8'h08);
        #1 chk("R7 count 0 ready", eng_rx_ready, 0);
        wr(3'd1, 8'h08);
        wr(3'd0, 8'h54);
        push(8'd40, acc, l);
        rd(3'd1, d);
        chk("R7 count 40 flag", d, 8'h08);
        wr(3'd1, 8'h08);

        // R8 R9: byte-by-byte SMBus block read
        wr(3'd5, 8'h00);
        for (int n = 1; n <= 6; n++) begin
            wr(3'd0, 8'h54);
            push(8'(n), acc, l);
            chk("R8 count accepted", acc, 1);
            for (int k = 0; k < n; k++) begin
                if (k == n - 1) wr(3'd0, 8'h34);
                push(pat(n, k), acc, l);
                chk("R8 accept", acc, 1);
                chk("R9 last code", l, (k == n - 1));
                push(8'hEE, acc, l);
                chk("R8 stall", acc, 0);
                rd(3'd1, d);
                chk("R8 byte done", d, 8'h80);
                rd(3'd4, d);
                chk("R8 byte", d, pat(n, k));
                wr(3'd1, 8'h80);
            end
            rd(3'd1, d);
            chk("R8 cleared", d, 0);
        end

        // R8: byte-by-byte block write
        wr(3'd7, 8'h50);
        wr(3'd2, 8'd3);
        wr(3'd4, pat(3, 0));
        wr(3'd0, 8'h54);
        for (int k = 0; k < 3; k++) begin
            pull(v, d, l);
            chk("R8 tx valid", v, 1);
            chk("R8 tx data", d, pat(3, k));
            pull(v, d, l);
            chk("R8 tx stall", v, 0);
            rd(3'd1, d);
            chk("R8 tx byte done", d, 8'h80);
            if (k < 2) wr(3'd4, pat(3, k + 1));
            wr(3'd1, 8'h80);
        end
        pull(v, d, l);
        chk("R8 tx end", v, 0);

        // R10: I2C-style read with the buffer enabled
        wr(3'd5, 8'h01);
        wr(3'd7, 8'hA1);
        wr(3'd6, 8'h11);
        wr(3'd3, 8'h22);
        wr(3'd2, 8'd3);
        wr(3'd0, 8'h58);
        chk("R10 addr", eng_addr_byte, 8'hA0);
        chk("R10 cmd", eng_cmd_byte, 8'h22);
        chk("R10 read", eng_read, 1);
        for (int k = 0; k < 3; k++) begin
            if (k == 2) wr(3'd0, 8'h38);
            push(pat(9, k), acc, l);
            chk("R10 accept", acc, 1);
            chk("R10 last", l, (k == 2));
            rd(3'd1, d);
            chk("R10 byte done", d, 8'h80);
            rd(3'd4, d);
            chk("R10 byte reg", d, pat(9, k));
            wr(3'd1, 8'h80);
        end
        rd(3'd2, d);
        chk("R10 data0 kept", d, 3);
        #1 chk("R10 end", eng_rx_ready, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule